// File: doc/BRIEF.md
# Buffered Manchester On-Off-Keyed Carrier Modulator

This block sits between a host write path and the power stage of a low-frequency coil transmitter. The host loads a short message into an eight-word, 16-bit (128-bit) first-in first-out store. The first word of a message is a header whose low byte gives the number of 4-bit data nibbles that follow. The data words come after it. On a start request the block compares the words that are present with the count the header declares. A consistent message is then played out as a Manchester-coded carrier-enable line, which switches the coil field on and off.

Timing comes from a carrier tick input, which pulses once per carrier period (every 8 µs in the intended system). A rate bit, sampled at the start request, sets each half-bit to 16 or 11 carrier periods. That gives bit times of 32 or 22 periods, about 3.9 or 5.7 kbit/s. A fault input silences the output at once and flushes the store.

Top module: `lf_ook_modulator`

## Requirements
- R1: A write with `wr_en` high and the store not full is stored. Words are consumed in the order they were written. `buf_empty` is high when no word is stored and `buf_full` is high when eight words are stored.
- R2: A `start` pulse is considered only while idle, with a non-empty store and no fault. It is accepted when the header's low byte N is non-zero and the number of words after the header equals ceil(N/4). A `start` pulse while empty has no effect.
- R3: `carrier_en` high means the field is on. A data bit of 1 is sent as its first half on and its second half off. A data bit of 0 is sent as its first half off and its second half on.
- R4: With `rate_sel` at 0 at acceptance, each half-bit lasts 16 carrier ticks. With 1, each half-bit lasts 11 ticks. Changes of `rate_sel` during a message have no effect on it.
- R5: The 4·N bits are sent most significant bit first from bit 15 of each word: the upper nibble goes first, and words go in stored order. Nibbles past N in the last word are skipped. After the last half-bit, `busy` drops and the store is empty.
- R6: A write while full is dropped and sets the sticky `ovf` flag. Only reset clears `ovf`.
- R7: A considered start that fails the count check sets `cons_err`, empties the store and leaves `busy` and `carrier_en` low. The next accepted start clears `cons_err`.
- R8: While `fault` is high, `carrier_en` is low in the same cycle. On the next edge the message is aborted, `busy` is low and the store is empty.
- R9: `carrier_en` is low whenever `busy` is low. After reset the outputs are: empty 1, full 0, busy 0, carrier 0, errors 0.
- R10: `busy` rises on the clock edge that accepts a start. `carrier_en` shows the first half of the first bit from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| rate_sel | input | 1 | 0: 16 ticks per half-bit, 1: 11 ticks per half-bit |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 16 | Host word: header (low byte = nibble count) or data |
| start | input | 1 | Request to check and send the stored message |
| fault | input | 1 | Abort, silence output and flush the store |
| carrier_en | output | 1 | Field enable to the coil driver |
| buf_empty | output | 1 | No word stored |
| buf_full | output | 1 | All eight words stored |
| busy | output | 1 | Message being sent |
| cons_err | output | 1 | Header count mismatch seen |
| ovf | output | 1 | Sticky write-while-full flag |

## Verification
The bench sweeps nibble counts from 1 to 28 at both rates, with uneven tick spacing. It predicts every cycle of `carrier_en` and `busy` from a tick count. A wrong half-bit length, a swapped Manchester phase or a wrong nibble order would show up as a stream shifted or inverted against the prediction. Partial last words (N not a multiple of four) expose a design that sends padding nibbles, or that stops one word early and leaves a stale word behind. Toggling `rate_sel` during a message catches a design that reads the rate live instead of latching it. A ninth write into a full store, a header that declares too many nibbles, a zero count, and a fault in mid-message check that nothing leaks onto the carrier, and that the store is left clean for the next message.

// File: rtl/lf_ook_modulator.sv
module lf_ook_modulator #(
  parameter int WORD_W    = 16,
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 8,
  parameter int HALF_SLOW = 16,
  parameter int HALF_FAST = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_tick,
  input  logic              rate_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic              fault,
  output logic              carrier_en,
  output logic              buf_empty,
  output logic              buf_full,
  output logic              busy,
  output logic              cons_err,
  output logic              ovf
);
  localparam int AW    = $clog2(DEPTH);
  localparam int OW    = $clog2(DEPTH + 1);
  localparam int NPW   = WORD_W / 4;
  localparam int TW    = $clog2(HALF_SLOW);
  localparam int BPW   = $clog2(WORD_W);
  localparam int BLW   = CNT_W + 2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [OW-1:0]     occ;
  logic              phase, rate_q;
  logic [TW-1:0]     tcnt, hl;
  logic [BPW-1:0]    bpos;
  logic [BLW-1:0]    bits_left;
  logic [WORD_W-1:0] sh;

  logic [CNT_W-1:0]  nib;
  logic [CNT_W:0]    need, occ_x;
  logic              frame_ok, start_go, accept, reject;
  logic              half_end, bit_end, last, load_next, wr_ok;
  logic [1:0]        rd_n;

  assign buf_empty  = (occ == '0);
  assign buf_full   = (occ == OW'(DEPTH));
  assign nib        = mem[rp][CNT_W-1:0];
  assign need       = ({1'b0, nib} + (CNT_W+1)'(NPW - 1)) / (CNT_W+1)'(NPW);
  assign occ_x      = (CNT_W+1)'(occ);
  assign frame_ok   = (nib != '0) && (occ_x - 1'b1 == need);
  assign start_go   = start && !busy && !buf_empty && !fault;
  assign accept     = start_go && frame_ok;
  assign reject     = start_go && !frame_ok;

  assign hl         = rate_q ? TW'(HALF_FAST - 1) : TW'(HALF_SLOW - 1);
  assign half_end   = busy && carrier_tick && (tcnt == hl);
  assign bit_end    = half_end && phase;
  assign last       = bit_end && (bits_left == BLW'(1));
  assign load_next  = bit_end && !last && (bpos == BPW'(WORD_W - 1));
  assign wr_ok      = wr_en && !buf_full && !fault && !reject;
  assign rd_n       = accept ? 2'd2 : (load_next ? 2'd1 : 2'd0);

  assign carrier_en = busy && !fault && (sh[WORD_W-1] ^ phase);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; occ <= '0;
      busy <= 1'b0; phase <= 1'b0; rate_q <= 1'b0; tcnt <= '0;
      bpos <= '0; bits_left <= '0; sh <= '0;
      cons_err <= 1'b0; ovf <= 1'b0;
    end else if (fault) begin
      wp <= '0; rp <= '0; occ <= '0;
      busy <= 1'b0; phase <= 1'b0; tcnt <= '0;
    end else begin
      if (wr_en && buf_full) ovf <= 1'b1;
      if (reject) begin
        wp <= '0; rp <= '0; occ <= '0;
        cons_err <= 1'b1;
      end else begin
        if (wr_ok) wp <= wp + 1'b1;
        rp  <= rp + AW'(rd_n);
        occ <= occ + OW'(wr_ok) - OW'(rd_n);
      end
      if (accept) begin
        busy      <= 1'b1;
        cons_err  <= 1'b0;
        rate_q    <= rate_sel;
        phase     <= 1'b0;
        tcnt      <= '0;
        bpos      <= '0;
        bits_left <= {nib, 2'b00};
        sh        <= mem[rp + AW'(1)];
      end else if (busy && carrier_tick) begin
        if (!half_end) begin
          tcnt <= tcnt + 1'b1;
        end else begin
          tcnt  <= '0;
          phase <= ~phase;
          if (phase) begin
            bits_left <= bits_left - 1'b1;
            if (last) begin
              busy <= 1'b0;
            end else if (load_next) begin
              sh   <= mem[rp];
              bpos <= '0;
            end else begin
              sh   <= sh << 1;
              bpos <= bpos + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/lf_ook_modulator_chk.sv
module lf_ook_modulator_chk (
  input logic clk,
  input logic rst_n,
  input logic fault,
  input logic start,
  input logic wr_en,
  input logic carrier_en,
  input logic busy,
  input logic buf_empty,
  input logic buf_full,
  input logic cons_err,
  input logic ovf
);
  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !carrier_en); // R8
  AST_FAULT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) fault |=> (buf_empty && !busy)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !carrier_en); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(buf_full && buf_empty)); // R1
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && buf_full && !fault) |=> ovf); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf); // R6
  AST_ERR_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n) $rose(cons_err) |-> (!busy && buf_empty)); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R10
endmodule

bind lf_ook_modulator lf_ook_modulator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .start(start), .wr_en(wr_en),
  .carrier_en(carrier_en), .busy(busy), .buf_empty(buf_empty),
  .buf_full(buf_full), .cons_err(cons_err), .ovf(ovf)
);

// File: tb/lf_ook_modulator_tb.sv
module lf_ook_modulator_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, carrier_tick, rate_sel, wr_en, start, fault;
  logic [15:0] wr_data;
  logic carrier_en, buf_empty, buf_full, busy, cons_err, ovf;

  lf_ook_modulator u_dut (
    .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .rate_sel(rate_sel),
    .wr_en(wr_en), .wr_data(wr_data), .start(start), .fault(fault),
    .carrier_en(carrier_en), .buf_empty(buf_empty), .buf_full(buf_full),
    .busy(busy), .cons_err(cons_err), .ovf(ovf)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [15:0] dword(input int n, input int i);
    return 16'((i + 1) * 40503 + n * 7919 + 3);
  endfunction

  task automatic wr(input logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill(input int n);
    wr({8'h00, 8'(n)});
    for (int i = 0; i < (n + 3) / 4; i++) wr(dword(n, i));
  endtask

  task automatic play(input int n, input bit r, input int tp, input bit tog);
    int hl, total, t, cyc, hi, j;
    logic [15:0] w;
    logic e_en;
    hl = r ? 11 : 16;
    total = n * 8 * hl;
    t = 0; cyc = 0;
    carrier_tick = 1'b0;
    start = 1'b1; rate_sel = r;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy after accepted start", busy, 1);
    forever begin
      hi = t / hl;
      j = hi / 2;
      w = dword(n, j / 16);
      e_en = (t < total) ? (w[15 - (j % 16)] ^ hi[0]) : 1'b0;
      chk(carrier_en === e_en, r ? "R3 R4 R5 fast stream" : "R3 R4 R5 slow stream", carrier_en, e_en);
      chk(busy === (t < total), "R5 busy span", busy, int'(t < total));
      if (t >= total) break;
      carrier_tick = ((cyc % tp) == 0);
      if (tog) rate_sel = ~rate_sel;
      cyc++;
      @(posedge clk);
      if (carrier_tick) t++;
      @(negedge clk);
    end
    carrier_tick = 1'b0;
    rate_sel = r;
    chk(buf_empty === 1'b1, "R5 store empty after message", buf_empty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    summary();
    $finish;
  end

  initial begin
    int sizes[7] = '{1, 2, 3, 4, 5, 8, 13};
    rst_n = 1'b0; carrier_tick = 1'b0; rate_sel = 1'b0; wr_en = 1'b0;
    wr_data = '0; start = 1'b0; fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(buf_empty === 1'b1, "R9 reset empty", buf_empty, 1);
    chk(buf_full === 1'b0, "R9 reset full", buf_full, 0);
    chk(busy === 1'b0, "R9 reset busy", busy, 0);
    chk(carrier_en === 1'b0, "R9 reset carrier", carrier_en, 0);
    chk(cons_err === 1'b0 && ovf === 1'b0, "R9 reset errors", cons_err + ovf, 0);

    // R2 start on empty store ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy === 1'b0 && cons_err === 1'b0, "R2 start while empty", busy + cons_err, 0);

    // R1 R3 R4 R5 sweep of sizes and rates
    foreach (sizes[k]) begin
      for (int r = 0; r < 2; r++) begin
        fill(sizes[k]);
        chk(buf_empty === 1'b0, "R1 not empty after writes", buf_empty, 0);
        play(sizes[k], r[0], 1 + (sizes[k] % 3), sizes[k] == 5 || sizes[k] == 13);
      end
    end

    // R6 full store and dropped write
    fill(28);
    chk(buf_full === 1'b1, "R1 full at eight words", buf_full, 1);
    chk(ovf === 1'b0, "R6 no overflow yet", ovf, 0);
    wr(16'hFFFF);
    chk(ovf === 1'b1, "R6 overflow set", ovf, 1);
    play(28, 1'b1, 1, 1'b0);
    fill(28);
    play(28, 1'b0, 2, 1'b0);
    chk(ovf === 1'b1, "R6 overflow sticky", ovf, 1);

    // R7 count mismatch: header says 5 nibbles, one word follows
    wr(16'h0005);
    wr(16'hFFFF);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(cons_err === 1'b1, "R7 mismatch flagged", cons_err, 1);
    chk(buf_empty === 1'b1, "R7 store flushed", buf_empty, 1);
    for (int c = 0; c < 40; c++) begin
      carrier_tick = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && carrier_en === 1'b0, "R7 no keying", carrier_en, 0);
    end
    carrier_tick = 1'b0;
    // R7 zero count header
    wr(16'h0000);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(cons_err === 1'b1 && busy === 1'b0, "R7 zero count rejected", busy, 0);
    chk(buf_empty === 1'b1, "R7 zero count flushed", buf_empty, 1);
    fill(2);
    play(2, 1'b0, 1, 1'b0);
    chk(cons_err === 1'b0, "R7 cleared by accepted start", cons_err, 0);

    // R8 fault mid message
    fill(8);
    start = 1'b1; rate_sel = 1'b0; @(negedge clk); start = 1'b0;
    for (int c = 0; c < 50; c++) begin
      carrier_tick = 1'b1;
      @(negedge clk);
    end
    carrier_tick = 1'b0;
    chk(busy === 1'b1, "R8 busy before fault", busy, 1);
    wr_en = 1'b1; wr_data = 16'h1234;
    fault = 1'b1;
    #1;
    chk(carrier_en === 1'b0, "R8 carrier low with fault", carrier_en, 0);
    @(negedge clk);
    fault = 1'b0; wr_en = 1'b0;
    chk(busy === 1'b0, "R8 aborted", busy, 0);
    chk(buf_empty === 1'b1, "R8 store flushed", buf_empty, 1);
    chk(carrier_en === 1'b0, "R9 carrier low when idle", carrier_en, 0);
    fill(3);
    play(3, 1'b1, 3, 1'b0);

    summary();
    $finish;
  end
endmodule